// File: doc/BRIEF.md
# Phase Detector Control and Output Routing

This block is the digital core of a tri-state phase-frequency detector for a frequency synthesiser loop. It takes single-cycle strobes from the reference divider and from the main divider and drives UP and DOWN correction levels for two charge-pump channels. A flag is set by the strobe that arrives first and held until the other strobe arrives. Once both flags are set they clear together on the next cycle. The detector therefore stays linear over a full cycle of phase error and has no dead band.

A sense input sets the correction polarity. It also swaps the two monitor ports, which carry registered copies of the divider strobes so that an external detector can use them. Two mode bits control the monitor ports and the fast pump (channel 1). Depending on the mode, that pump is always enabled, always disabled, or switched off while the debounced lock indication is active. The slow pump (channel 2) follows the detector at all times.

The gain setting is passed on only as an index. The analog current levels behind it are outside this block.

Top module: `pfd_ctrl`

## Requirements
- R1: With `sense`=0, a `ref_stb` pulse sets the UP flag and a `div_stb` pulse sets the DOWN flag. With `sense`=1 the two roles swap. The flags appear on `cp2_up`/`cp2_dn` one clock after the strobe is sampled.
- R2: A flag that is set stays high on following cycles until the opposite flag is also set.
- R3: When both flags are high they both go low on the next clock. A strobe sampled in that clearing cycle sets its own flag again. Simultaneous strobes give a one-cycle pulse on both UP and DOWN.
- R4: The monitor ports are one-cycle registered copies of the strobes and are enabled only while `mode_pd1`=1. With `sense`=0, `mon_a` carries `div_stb` and `mon_b` carries `ref_stb`. With `sense`=1 the two are swapped.
- R5: In mode (`mode_pd1`,`mode_pd2`)=(0,0), `cp1_up`/`cp1_dn` equal `cp2_up`/`cp2_dn`.
- R6: In mode (1,0), `cp1_up` and `cp1_dn` stay low.
- R7: When `mode_pd2`=1, `cp1_up`/`cp1_dn` are low while `lock_n` is low and follow the detector while `lock_n` is high. `cp2_up`/`cp2_dn` are never gated by any mode.
- R8: `gain_idx` is combinational from `gain_sel`={G2,G1}: 00→0, 10→1, 01→2, 11→3. The indices stand for fast-pump levels of 50/75/125/200 and slow-pump multipliers of 1/1.5/2.5/4.
- R9: `lock_n` falls at the rising edge where `lock_raw` has been sampled high on `lock_hold`+1 consecutive edges. It rises at the first edge that samples `lock_raw` low.
- R10: During and after reset all pump and monitor outputs are low and `lock_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | Reference divider strobe, one cycle |
| div_stb | input | 1 | Main divider strobe, one cycle |
| sense | input | 1 | Polarity and monitor swap control |
| mode_pd1 | input | 1 | Mode bit 1: monitor enable / fast pump force-off |
| mode_pd2 | input | 1 | Mode bit 2: lock gating of fast pump |
| gain_sel | input | 2 | Gain code {G2,G1} |
| lock_raw | input | 1 | Undebounced lock status |
| lock_hold | input | CNT_W | Debounce length in cycles |
| cp1_up | output | 1 | Fast pump UP |
| cp1_dn | output | 1 | Fast pump DOWN |
| cp2_up | output | 1 | Slow pump UP |
| cp2_dn | output | 1 | Slow pump DOWN |
| mon_a | output | 1 | Monitor port A |
| mon_b | output | 1 | Monitor port B |
| gain_idx | output | 2 | Gain level index |
| lock_n | output | 1 | Debounced lock, active low |

## Verification
Two collisions are provoked on purpose. The first is the clear of a both-set detector state meeting a new strobe in the same cycle, and also two strobes arriving together. The bench expects the new strobe to set its flag again, and expects a single one-cycle pulse on both UP and DOWN. The second is the debounced lock asserting in the same cycle as detector activity while lock gating is selected. The bench expects the fast pump to drop in exactly that cycle while the slow pump carries on. A cycle-level model in the bench predicts every output and queues the prediction. A monitor then compares each queued prediction against the design at the matching edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Gain code {G2,G1} to level index: 00->0, 10->1, 01->2, 11->3
  function automatic logic [1:0] gain_index(input logic g2, input logic g1);
    return {g1, g2};
  endfunction

  // Fast pump enable from mode bits and debounced lock
  function automatic logic fast_pump_on(input logic pd1, input logic pd2,
                                        input logic locked);
    if (pd2) return !locked;
    return !pd1;
  endfunction

endpackage

// File: rtl/pfd_tristate.sv
module pfd_tristate (
  input  logic clk,
  input  logic rst_n,
  input  logic up_set,
  input  logic dn_set,
  output logic up_q,
  output logic dn_q
);
  logic both_set;
  assign both_set = up_q & dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both_set) begin
      up_q <= up_set;
      dn_q <= dn_set;
    end else begin
      up_q <= up_q | up_set;
      dn_q <= dn_q | dn_set;
    end
  end

  // R3
  both_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !up_set && !dn_set) |=> (!up_q && !dn_q));

  // R1
  up_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_set |=> up_q);

  // R2
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !dn_q && !dn_set) |=> up_q);

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_raw,
  input  logic [CNT_W-1:0] hold,
  output logic             locked
);
  logic [CNT_W-1:0] run_cnt;
  logic             run_done;
  assign run_done = (run_cnt >= hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (!lock_raw) begin
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (run_done) begin
      locked  <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_raw |=> !locked);

  // R9
  lock_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lock_raw));

endmodule

// File: rtl/pfd_monitor_route.sv
module pfd_monitor_route (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sense,
  input  logic ref_stb,
  input  logic div_stb,
  output logic mon_a,
  output logic mon_b
);
  logic a_src, b_src;
  assign a_src = sense ? ref_stb : div_stb;
  assign b_src = sense ? div_stb : ref_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_a <= 1'b0;
      mon_b <= 1'b0;
    end else begin
      mon_a <= enable & a_src;
      mon_b <= enable & b_src;
    end
  end

  // R4
  mon_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mon_a && !mon_b));

endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb,
  input  logic             div_stb,
  input  logic             sense,
  input  logic             mode_pd1,
  input  logic             mode_pd2,
  input  logic [1:0]       gain_sel,
  input  logic             lock_raw,
  input  logic [CNT_W-1:0] lock_hold,
  output logic             cp1_up,
  output logic             cp1_dn,
  output logic             cp2_up,
  output logic             cp2_dn,
  output logic             mon_a,
  output logic             mon_b,
  output logic [1:0]       gain_idx,
  output logic             lock_n
);
  import pfd_pkg::*;

  logic up_set, dn_set;
  logic det_up, det_dn;
  logic locked;
  logic fast_en;

  // Sense swaps which divider drives the UP flag
  assign up_set = sense ? div_stb : ref_stb;
  assign dn_set = sense ? ref_stb : div_stb;

  pfd_tristate i_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_set (up_set),
    .dn_set (dn_set),
    .up_q   (det_up),
    .dn_q   (det_dn)
  );

  pfd_lock_filter #(.CNT_W(CNT_W)) i_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_raw (lock_raw),
    .hold     (lock_hold),
    .locked   (locked)
  );

  pfd_monitor_route i_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (mode_pd1),
    .sense   (sense),
    .ref_stb (ref_stb),
    .div_stb (div_stb),
    .mon_a   (mon_a),
    .mon_b   (mon_b)
  );

  assign fast_en  = fast_pump_on(mode_pd1, mode_pd2, locked);
  assign cp1_up   = det_up & fast_en;
  assign cp1_dn   = det_dn & fast_en;
  assign cp2_up   = det_up;
  assign cp2_dn   = det_dn;
  assign gain_idx = gain_index(gain_sel[1], gain_sel[0]);
  assign lock_n   = ~locked;

  // R6
  fast_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pd1 && !mode_pd2) |-> (!cp1_up && !cp1_dn));

  // R7
  fast_lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pd2 && !lock_n) |-> (!cp1_up && !cp1_dn));

  // R5
  fast_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pd1 && !mode_pd2) |-> (cp1_up == cp2_up && cp1_dn == cp2_dn));

endmodule

// File: tb/test_pfd_ctrl.sv
module test_pfd_ctrl;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_stb, div_stb, sense, mode_pd1, mode_pd2, lock_raw;
  logic [1:0] gain_sel;
  logic [CW-1:0] lock_hold;
  logic cp1_up, cp1_dn, cp2_up, cp2_dn, mon_a, mon_b, lock_n;
  logic [1:0] gain_idx;

  always #2.5 clk = ~clk;

  pfd_ctrl #(.CNT_W(CW)) i_pfd_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .div_stb(div_stb),
    .sense(sense), .mode_pd1(mode_pd1), .mode_pd2(mode_pd2),
    .gain_sel(gain_sel), .lock_raw(lock_raw), .lock_hold(lock_hold),
    .cp1_up(cp1_up), .cp1_dn(cp1_dn), .cp2_up(cp2_up), .cp2_dn(cp2_dn),
    .mon_a(mon_a), .mon_b(mon_b), .gain_idx(gain_idx), .lock_n(lock_n)
  );

  typedef struct {
    string      tag;
    logic       p1u, p1d, p2u, p2d, ma, mb, ln;
    logic [1:0] g;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // shadow stimulus, applied at the falling edge by the driver
  logic s_sense = 0, s_pd1 = 0, s_pd2 = 0, s_raw = 0;
  logic [1:0] s_gain = 0;
  logic [CW-1:0] s_hold = 3;

  // bench model state
  logic m_up = 0, m_dn = 0, m_lock = 0;
  int   m_run = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic d, input string tag);
    exp_t e;
    logic first, second, both, fast;
    @(negedge clk);
    ref_stb = r; div_stb = d; sense = s_sense; mode_pd1 = s_pd1;
    mode_pd2 = s_pd2; gain_sel = s_gain; lock_raw = s_raw; lock_hold = s_hold;
    if (s_sense == 1'b0) begin first = r; second = d; end
    else begin first = d; second = r; end
    both = m_up && m_dn;
    if (both) begin m_up = first; m_dn = second; end
    else begin m_up = m_up || first; m_dn = m_dn || second; end
    if (!s_raw) begin m_run = 0; m_lock = 0; end
    else if (m_run >= int'(s_hold)) m_lock = 1;
    else m_run++;
    case ({s_pd1, s_pd2})
      2'b00: fast = 1;
      2'b10: fast = 0;
      default: fast = !m_lock;
    endcase
    e.tag = tag;
    e.p2u = m_up; e.p2d = m_dn;
    e.p1u = m_up && fast; e.p1d = m_dn && fast;
    e.ma = s_pd1 && (s_sense ? r : d);
    e.mb = s_pd1 && (s_sense ? d : r);
    e.ln = !m_lock;
    case (s_gain)
      2'b00: e.g = 2'd0;
      2'b10: e.g = 2'd1;
      2'b01: e.g = 2'd2;
      default: e.g = 2'd3;
    endcase
    q.push_back(e);
  endtask

  // monitor: compares one queued prediction per rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "cp2_up", cp2_up, e.p2u);
        chk(e.tag, "cp2_dn", cp2_dn, e.p2d);
        chk(e.tag, "cp1_up", cp1_up, e.p1u);
        chk(e.tag, "cp1_dn", cp1_dn, e.p1d);
        chk(e.tag, "mon_a", mon_a, e.ma);
        chk(e.tag, "mon_b", mon_b, e.mb);
        chk(e.tag, "gain_idx", gain_idx, e.g);
        chk(e.tag, "lock_n", lock_n, e.ln);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ref_stb = 0; div_stb = 0; sense = 0; mode_pd1 = 0;
    mode_pd2 = 0; gain_sel = 0; lock_raw = 0; lock_hold = 3;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "cp1_up", cp1_up, 0); chk("R10", "cp2_dn", cp2_dn, 0);
    chk("R10", "mon_a", mon_a, 0);   chk("R10", "lock_n", lock_n, 1);
    rst_n = 1;

    // R1 / R2 / R3, sense 0, mode 00
    cyc(1, 0, "R1"); cyc(0, 0, "R2"); cyc(0, 0, "R2");
    cyc(0, 1, "R3"); cyc(0, 0, "R3"); cyc(0, 0, "R3");
    cyc(0, 1, "R1"); cyc(0, 0, "R2"); cyc(1, 0, "R3"); cyc(0, 0, "R3");
    // R1 sense reversed
    s_sense = 1;
    cyc(1, 0, "R1"); cyc(0, 0, "R2"); cyc(0, 1, "R1"); cyc(0, 0, "R3");
    s_sense = 0;
    // R3 simultaneous strobes, and a strobe in the clearing cycle
    cyc(1, 1, "R3"); cyc(0, 0, "R3");
    cyc(1, 0, "R3"); cyc(0, 1, "R3"); cyc(1, 0, "R3"); cyc(0, 0, "R3");
    cyc(0, 1, "R3"); cyc(0, 0, "R3");
    // R5 mode 00 fast pump follows, monitors off
    cyc(0, 1, "R5"); cyc(0, 0, "R5"); cyc(1, 0, "R4"); cyc(0, 0, "R5");
    // R6 / R4 mode 10
    s_pd1 = 1; s_pd2 = 0;
    cyc(1, 0, "R6"); cyc(0, 1, "R4"); cyc(0, 0, "R6");
    s_sense = 1;
    cyc(1, 0, "R4"); cyc(0, 1, "R4"); cyc(0, 0, "R4");
    s_sense = 0;
    // R8 gain codes
    for (int k = 0; k < 4; k++) begin
      s_gain = k[1:0];
      cyc(0, 0, "R8");
    end
    // R9 / R7 lock debounce and gating, mode 01
    s_pd1 = 0; s_pd2 = 1; s_hold = 3; s_raw = 1;
    cyc(1, 0, "R7"); cyc(0, 0, "R9"); cyc(0, 0, "R9");
    cyc(0, 0, "R9"); cyc(0, 0, "R7"); cyc(0, 1, "R7"); cyc(0, 0, "R7");
    s_raw = 0;
    cyc(1, 0, "R9"); cyc(0, 0, "R7");
    s_raw = 1;
    cyc(0, 0, "R9"); s_raw = 0; cyc(0, 1, "R9");
    // R7 mode 11, zero hold: lock in the same cycle as detector activity
    s_pd1 = 1; s_pd2 = 1; s_hold = 0; s_raw = 1;
    cyc(1, 0, "R7"); cyc(0, 0, "R7"); cyc(0, 1, "R7"); cyc(0, 0, "R7");
    s_raw = 0;
    cyc(1, 0, "R7"); cyc(0, 1, "R7"); cyc(0, 0, "R7");
    // R9 longer hold
    s_hold = 6; s_raw = 1;
    for (int k = 0; k < 9; k++) cyc(0, 0, "R9");

    @(negedge clk); ref_stb = 0; div_stb = 0;
    repeat (3) @(posedge clk);
    #2;
    if (q.size() != 0) chk("R1", "queue_left", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule